// File: doc/BRIEF.md
# Oversampled Serial Frame Receiver

This block takes a serial line that is sampled at eight receive-clock periods per bit. It finds the start of a message and turns the serial words into bytes. Each finished byte passes through a two-stage buffer to a host. The host collects a byte with an active-low read strobe. Three status outputs report the receiver: a flag that a message is in progress, a flag that a byte is ready, and an error flag. A small error code goes with the error flag.

Two serial sources feed the receiver. The primary line carries normal traffic. The alternate input carries test patterns and lets the receiver exercise itself without disturbing the line. A select input chooses between the two sources, and a disable input forces the chosen input to the idle level.

Line format. The idle level is 0. A message opens with at least PRE_LEN consecutive 1 bits, followed by a single 0 sync bit. After that, each item begins with a marker bit:
- A marker of 1 is followed by 8 data bits, least significant bit first, and then an even-parity bit.
- A marker of 0 ends the message.

Top module: `osr_rx_top`

## Requirements
- R1: After reset, rxActive, dataAvail and err are 0, errCode is 3'b000 and dataOut is 0.
- R2: With dataCtl at 0 the receiver decodes altIn. With dataCtl at 1 it decodes lineIn. Traffic on the unselected input has no effect.
- R3: While rxDis is 1, the selected input is treated as idle (0). A complete message sent in that state raises neither rxActive nor dataAvail.
- R4: rxActive rises after PRE_LEN (default 4) or more consecutive 1 bits followed by a 0 sync bit. A run of fewer 1 bits before the 0 leaves rxActive at 0.
- R5: A marker of 0 ends the message. rxActive then falls and err stays 0.
- R6: When a word with correct even parity completes and the holding register is free, dataAvail becomes 1 and dataOut shows the byte.
- R7: While rdN is 0, dataOut is stable. When rdN returns to 1, dataAvail drops to 0 for exactly one cycle. If a second byte is waiting, that byte then appears on dataOut and dataAvail returns to 1.
- R8: After the last byte is read, dataAvail stays 0 and dataOut keeps that byte.
- R9: A parity mismatch sets err to 1 and errCode to 3'b001. It clears rxActive and dataAvail in the same cycle.
- R10: Inside a message, a line transition seen in sub-bit phases 2 to 5 is a timing error. It sets errCode to 3'b010 and aborts the message.
- R11: A word that completes while an earlier byte is still waiting behind the holding register is an overrun. It sets errCode to 3'b100.
- R12: A one-cycle pulse on errRead returns err to 0 and errCode to 0. A new valid start sequence also clears them.
- R13: The bit phase restarts at every line transition. Bits stretched to 9 clocks or shortened to 7 clocks are still decoded correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock, eight times the bit rate |
| rstN | input | 1 | Asynchronous active-low reset |
| lineIn | input | 1 | Primary serial source |
| altIn | input | 1 | Alternate serial source, used for self-test |
| dataCtl | input | 1 | Source select: 0 selects altIn, 1 selects lineIn |
| rxDis | input | 1 | 1 forces the selected source to idle |
| rdN | input | 1 | Active-low read strobe for the holding register |
| errRead | input | 1 | Pulse that reads and clears the error code |
| rxActive | output | 1 | A message is being received |
| dataAvail | output | 1 | The holding register has an unread byte |
| err | output | 1 | An error has been detected |
| errCode | output | 3 | Error code: 001 parity, 010 timing, 100 overrun |
| dataOut | output | DATA_W | Holding register contents |

## Verification
The bench drives the release of the read strobe while a second byte is waiting and checks the one-cycle drop of dataAvail edge by edge. A design that moved the byte while the strobe was still low would change dataOut during the read. A design with no drop would never show dataAvail at 0 between the two bytes.

Each error kind is raised on its own: a flipped parity bit, a one-clock glitch in the middle of a bit, and a third word sent with no reads. Each must give its own error code and clear both status flags. Both ways of clearing an error are checked, so a receiver that ignored the new start sequence would leave err set.

Further directed cases cover the following:
- Words whose bits are 7 and 9 clocks long. These fail if the bit phase does not restart at transitions.
- A preamble one bit too short. A receiver that accepted it would raise rxActive.
- Traffic on the unselected source, and traffic while the receiver is disabled. Either one reaching the decoder would raise rxActive.

// File: rtl/osr_rx_pkg.sv
package osr_rx_pkg;

  typedef struct packed {
    logic shiftEn;
    logic wordDone;
    logic flush;
  } dpCtl_t;

  typedef enum logic [1:0] {
    ST_HUNT,
    ST_MARK,
    ST_DATA
  } rxState_e;

  localparam int ERR_W = 3;
  localparam logic [ERR_W-1:0] ERR_NONE    = 3'b000;
  localparam logic [ERR_W-1:0] ERR_PARITY  = 3'b001;
  localparam logic [ERR_W-1:0] ERR_TIMING  = 3'b010;
  localparam logic [ERR_W-1:0] ERR_OVERRUN = 3'b100;

endpackage

// File: rtl/osr_rx_bitrec.sv
module osr_rx_bitrec #(
  parameter int OSR         = 8,
  parameter int SAMPLE_PH   = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic lineIn,
  input  logic altIn,
  input  logic dataCtl,
  input  logic rxDis,
  output logic sampleStb,
  output logic bitVal,
  output logic timingViol
);

  localparam int PH_W    = $clog2(OSR);
  localparam int VIOL_LO = SAMPLE_PH - 1;
  localparam int VIOL_HI = SAMPLE_PH + 2;

  logic selIn;
  logic [SYNC_STAGES:0] syncQ;
  logic lineS;
  logic lineQ;
  logic lineEdge;
  logic [PH_W-1:0] ph;
  logic [PH_W-1:0] curPh;

  // The disable input forces the idle level; the select input picks the source.
  assign selIn = rxDis ? 1'b0 : (dataCtl ? lineIn : altIn);

  // Synchronizer chain plus one extra stage used for edge detection.
  generate
    for (genvar s = 0; s <= SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[0] <= 1'b0;
          else       syncQ[0] <= selIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[s] <= 1'b0;
          else       syncQ[s] <= syncQ[s-1];
        end
      end
    end
  endgenerate

  assign lineS    = syncQ[SYNC_STAGES-1];
  assign lineQ    = syncQ[SYNC_STAGES];
  assign lineEdge = lineS ^ lineQ;

  // A transition marks phase 0 of a new bit.
  assign curPh = lineEdge ? '0 : ph;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                           ph <= '0;
    else if (curPh == PH_W'(OSR - 1))    ph <= '0;
    else                                 ph <= curPh + 1'b1;
  end

  assign sampleStb  = (curPh == PH_W'(SAMPLE_PH));
  assign bitVal     = lineS;
  assign timingViol = lineEdge && (ph >= PH_W'(VIOL_LO)) && (ph <= PH_W'(VIOL_HI));

endmodule

// File: rtl/osr_rx_dp.sv
module osr_rx_dp
  import osr_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            dpCtl,
  input  logic              bitVal,
  input  logic              rdN,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataAvail,
  output logic              pendValid,
  output logic              parityBad
);

  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] pendByte;
  logic [DATA_W-1:0] holdReg;
  logic holdValid;
  logic pendV;
  logic rdPrev;
  logic rdRise;
  logic moveNow;

  assign rdRise    = rdN & ~rdPrev;
  assign moveNow   = pendV & ~holdValid & rdN & ~rdRise;
  // The current bit is the parity bit when this is consulted.
  assign parityBad = ^{shiftReg, bitVal};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftReg <= '0;
    else if (dpCtl.shiftEn) shiftReg <= {bitVal, shiftReg[DATA_W-1:1]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdPrev <= 1'b1;
    else       rdPrev <= rdN;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendByte  <= '0;
      pendV     <= 1'b0;
      holdReg   <= '0;
      holdValid <= 1'b0;
    end else if (dpCtl.flush) begin
      pendV     <= 1'b0;
      holdValid <= 1'b0;
    end else begin
      if (rdRise) begin
        holdValid <= 1'b0;
      end else if (moveNow) begin
        holdReg   <= pendByte;
        holdValid <= 1'b1;
        pendV     <= 1'b0;
      end
      if (dpCtl.wordDone) begin
        pendByte <= shiftReg;
        pendV    <= 1'b1;
      end
    end
  end

  assign dataOut   = holdReg;
  assign dataAvail = holdValid;
  assign pendValid = pendV;

endmodule

// File: rtl/osr_rx_ctrl.sv
module osr_rx_ctrl
  import osr_rx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int PRE_LEN = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleStb,
  input  logic             bitVal,
  input  logic             timingViol,
  input  logic             parityBad,
  input  logic             pendValid,
  input  logic             errRead,
  output dpCtl_t           dpCtl,
  output logic             rxActive,
  output logic             err,
  output logic [ERR_W-1:0] errCode
);

  localparam int ONES_W = $clog2(PRE_LEN + 1);
  localparam int CNT_W  = $clog2(DATA_W + 1);

  rxState_e state;
  logic [ONES_W-1:0] onesCnt;
  logic [CNT_W-1:0]  bitCnt;
  logic lastBit;
  logic startDet;
  logic errHit;
  logic [ERR_W-1:0] errVal;

  assign lastBit  = (state == ST_DATA) && (bitCnt == CNT_W'(DATA_W));
  assign startDet = (state == ST_HUNT) && sampleStb && !bitVal &&
                    (onesCnt == ONES_W'(PRE_LEN));

  always_comb begin
    errHit = 1'b0;
    errVal = ERR_NONE;
    if ((state != ST_HUNT) && timingViol) begin
      errHit = 1'b1;
      errVal = ERR_TIMING;
    end else if (lastBit && sampleStb) begin
      if (parityBad) begin
        errHit = 1'b1;
        errVal = ERR_PARITY;
      end else if (pendValid) begin
        errHit = 1'b1;
        errVal = ERR_OVERRUN;
      end
    end
  end

  always_comb begin
    dpCtl.shiftEn  = (state == ST_DATA) && sampleStb && !lastBit;
    dpCtl.wordDone = lastBit && sampleStb && !errHit;
    dpCtl.flush    = errHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_HUNT;
      onesCnt  <= '0;
      bitCnt   <= '0;
      rxActive <= 1'b0;
    end else if (errHit) begin
      state    <= ST_HUNT;
      onesCnt  <= '0;
      rxActive <= 1'b0;
    end else begin
      unique case (state)
        ST_HUNT: begin
          if (sampleStb) begin
            if (bitVal) begin
              if (onesCnt != ONES_W'(PRE_LEN)) onesCnt <= onesCnt + 1'b1;
            end else begin
              onesCnt <= '0;
              if (startDet) begin
                state    <= ST_MARK;
                rxActive <= 1'b1;
              end
            end
          end
        end
        ST_MARK: begin
          if (sampleStb) begin
            if (bitVal) begin
              state  <= ST_DATA;
              bitCnt <= '0;
            end else begin
              state    <= ST_HUNT;
              rxActive <= 1'b0;
            end
          end
        end
        ST_DATA: begin
          if (sampleStb) begin
            if (lastBit) state  <= ST_MARK;
            else         bitCnt <= bitCnt + 1'b1;
          end
        end
        default: state <= ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      err     <= 1'b0;
      errCode <= ERR_NONE;
    end else if (errHit) begin
      err     <= 1'b1;
      errCode <= errVal;
    end else if (startDet || errRead) begin
      err     <= 1'b0;
      errCode <= ERR_NONE;
    end
  end

endmodule

// File: rtl/osr_rx_top.sv
module osr_rx_top
  import osr_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OSR         = 8,
  parameter int SAMPLE_PH   = 3,
  parameter int SYNC_STAGES = 2,
  parameter int PRE_LEN     = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lineIn,
  input  logic              altIn,
  input  logic              dataCtl,
  input  logic              rxDis,
  input  logic              rdN,
  input  logic              errRead,
  output logic              rxActive,
  output logic              dataAvail,
  output logic              err,
  output logic [2:0]        errCode,
  output logic [DATA_W-1:0] dataOut
);

  dpCtl_t dpCtl;
  logic sampleStb;
  logic bitVal;
  logic timingViol;
  logic parityBad;
  logic pendValid;

  osr_rx_bitrec #(
    .OSR(OSR), .SAMPLE_PH(SAMPLE_PH), .SYNC_STAGES(SYNC_STAGES)
  ) u_bitrec (
    .clk(clk), .rstN(rstN), .lineIn(lineIn), .altIn(altIn),
    .dataCtl(dataCtl), .rxDis(rxDis), .sampleStb(sampleStb),
    .bitVal(bitVal), .timingViol(timingViol)
  );

  osr_rx_ctrl #(.DATA_W(DATA_W), .PRE_LEN(PRE_LEN)) u_ctrl (
    .clk(clk), .rstN(rstN), .sampleStb(sampleStb), .bitVal(bitVal),
    .timingViol(timingViol), .parityBad(parityBad), .pendValid(pendValid),
    .errRead(errRead), .dpCtl(dpCtl), .rxActive(rxActive), .err(err),
    .errCode(errCode)
  );

  osr_rx_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .dpCtl(dpCtl), .bitVal(bitVal), .rdN(rdN),
    .dataOut(dataOut), .dataAvail(dataAvail), .pendValid(pendValid),
    .parityBad(parityBad)
  );

endmodule

// File: rtl/osr_rx_chk.sv
module osr_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              rdN,
  input logic              errRead,
  input logic              rxActive,
  input logic              dataAvail,
  input logic              err,
  input logic [2:0]        errCode,
  input logic [DATA_W-1:0] dataOut
);

  p_err_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    err |-> (!rxActive && !dataAvail));

  p_hold_stable_r7: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rdN) |-> $stable(dataOut));

  p_release_dip_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rdN && !$past(rdN)) |=> !dataAvail);

  p_code_onehot_r11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(errCode));

  p_err_release_r12: assert property (@(posedge clk) disable iff (!rstN)
    $fell(err) |-> ($past(errRead) || rxActive));

endmodule

bind osr_rx_top osr_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .rdN(rdN), .errRead(errRead),
  .rxActive(rxActive), .dataAvail(dataAvail), .err(err),
  .errCode(errCode), .dataOut(dataOut)
);

// File: tb/osr_rx_top_tb.sv
`timescale 1ns/100ps
module osr_rx_top_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lineIn = 1'b0, altIn = 1'b0, dataCtl = 1'b1, rxDis = 1'b0;
  logic rdN = 1'b1, errRead = 1'b0;
  logic rxActive, dataAvail, err;
  logic [2:0] errCode;
  logic [7:0] dataOut;
  logic useAlt = 1'b0;
  int nChk = 0, nFail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  osr_rx_top u_dut (
    .clk(clk), .rstN(rstN), .lineIn(lineIn), .altIn(altIn), .dataCtl(dataCtl),
    .rxDis(rxDis), .rdN(rdN), .errRead(errRead), .rxActive(rxActive),
    .dataAvail(dataAvail), .err(err), .errCode(errCode), .dataOut(dataOut)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic setLine(input logic v);
    if (useAlt) altIn = v; else lineIn = v;
  endtask

  task automatic sendBit(input logic v, input int len);
    setLine(v);
    repeat (len) @(negedge clk);
  endtask

  task automatic sendStart(input int ones);
    sendBit(1'b0, 16);
    for (int i = 0; i < ones; i++) sendBit(1'b1, 8);
    sendBit(1'b0, 8);
  endtask

  task automatic sendWord(input logic [7:0] b, input logic badPar, input int len);
    sendBit(1'b1, 8);
    for (int i = 0; i < 8; i++) sendBit(b[i], len);
    sendBit((^b) ^ badPar, len);
  endtask

  task automatic sendEnd();
    sendBit(1'b0, 8);
    sendBit(1'b0, 24);
  endtask

  task automatic pulseErrRead();
    errRead = 1'b1;
    @(negedge clk);
    errRead = 1'b0;
    @(negedge clk);
  endtask

  task automatic readByte(input string tag, input logic [7:0] cur,
                          input logic hasNext, input logic [7:0] nxt);
    rdN = 1'b0;
    repeat (3) @(negedge clk);
    chk({tag, " R7 dataOut stable while strobe low"}, dataOut, cur);
    chk({tag, " R7 dataAvail held while strobe low"}, dataAvail, 1'b1);
    rdN = 1'b1;
    @(posedge clk); #1;
    chk({tag, " R7 dataAvail dips after release"}, dataAvail, 1'b0);
    if (hasNext) begin
      @(posedge clk); #1;
      chk({tag, " R7 dataAvail back with next byte"}, dataAvail, 1'b1);
      chk({tag, " R7 next byte moved in"}, dataOut, nxt);
    end
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 rxActive", rxActive, 0);
    chk("R1 dataAvail", dataAvail, 0);
    chk("R1 err", err, 0);
    chk("R1 errCode", errCode, 0);
    chk("R1 dataOut", dataOut, 0);
  endtask

  task automatic t_basic();
    useAlt = 1'b0; dataCtl = 1'b1;
    sendStart(4);
    chk("R4 rxActive after start", rxActive, 1);
    sendWord(8'hA5, 1'b0, 8);
    chk("R6 dataAvail after first word", dataAvail, 1);
    chk("R6 first byte", dataOut, 8'hA5);
    sendWord(8'h3C, 1'b0, 8);
    sendEnd();
    chk("R5 rxActive falls at end marker", rxActive, 0);
    chk("R5 no error", err, 0);
    chk("R7 first byte still held", dataOut, 8'hA5);
    readByte("basic1", 8'hA5, 1'b1, 8'h3C);
    readByte("basic2", 8'h3C, 1'b0, 8'h00);
    repeat (4) @(negedge clk);
    chk("R8 dataAvail low after last read", dataAvail, 0);
    chk("R8 last byte retained", dataOut, 8'h3C);
  endtask

  task automatic t_short_pre();
    sendStart(3);
    sendBit(1'b0, 24);
    chk("R4 short preamble rejected", rxActive, 0);
  endtask

  task automatic t_source();
    useAlt = 1'b1; dataCtl = 1'b0;
    sendStart(4);
    chk("R2 alt source start", rxActive, 1);
    sendWord(8'h81, 1'b0, 8);
    sendEnd();
    chk("R2 alt source byte", dataOut, 8'h81);
    chk("R2 alt source avail", dataAvail, 1);
    readByte("alt", 8'h81, 1'b0, 8'h00);
    dataCtl = 1'b1;
    sendStart(4);
    chk("R2 unselected source ignored", rxActive, 0);
    sendWord(8'h42, 1'b0, 8);
    sendEnd();
    chk("R2 unselected source no byte", dataAvail, 0);
    useAlt = 1'b0;
  endtask

  task automatic t_disable();
    rxDis = 1'b1;
    sendStart(4);
    chk("R3 disabled no start", rxActive, 0);
    sendWord(8'h77, 1'b0, 8);
    sendEnd();
    chk("R3 disabled no byte", dataAvail, 0);
    chk("R3 disabled holding unchanged", dataOut, 8'h81);
    rxDis = 1'b0;
  endtask

  task automatic t_parity();
    sendStart(4);
    sendWord(8'h5A, 1'b0, 8);
    chk("R9 good byte before error", dataAvail, 1);
    sendWord(8'h12, 1'b1, 8);
    sendEnd();
    chk("R9 err set", err, 1);
    chk("R9 parity code", errCode, 3'b001);
    chk("R9 rxActive cleared", rxActive, 0);
    chk("R9 dataAvail cleared", dataAvail, 0);
    pulseErrRead();
    chk("R12 err cleared by read", err, 0);
    chk("R12 code cleared by read", errCode, 0);
  endtask

  task automatic t_timing();
    sendStart(4);
    sendBit(1'b1, 8);
    setLine(1'b0); repeat (4) @(negedge clk);
    setLine(1'b1); repeat (1) @(negedge clk);
    setLine(1'b0); repeat (3) @(negedge clk);
    sendBit(1'b0, 24);
    chk("R10 err set", err, 1);
    chk("R10 timing code", errCode, 3'b010);
    chk("R10 rxActive cleared", rxActive, 0);
    sendStart(4);
    chk("R12 err cleared by new start", err, 0);
    chk("R12 rxActive after new start", rxActive, 1);
    sendEnd();
  endtask

  task automatic t_overrun();
    sendStart(4);
    sendWord(8'h01, 1'b0, 8);
    sendWord(8'h02, 1'b0, 8);
    sendWord(8'h03, 1'b0, 8);
    sendEnd();
    chk("R11 err set", err, 1);
    chk("R11 overrun code", errCode, 3'b100);
    chk("R11 dataAvail cleared", dataAvail, 0);
    pulseErrRead();
    chk("R12 overrun cleared", errCode, 0);
  endtask

  task automatic t_resync();
    sendStart(4);
    sendWord(8'h55, 1'b0, 9);
    sendEnd();
    chk("R13 long bits no error", err, 0);
    chk("R13 long bits byte", dataOut, 8'h55);
    readByte("long", 8'h55, 1'b0, 8'h00);
    sendStart(4);
    sendWord(8'hAA, 1'b0, 7);
    sendEnd();
    chk("R13 short bits no error", err, 0);
    chk("R13 short bits byte", dataOut, 8'hAA);
    readByte("short", 8'hAA, 1'b0, 8'h00);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_short_pre();
    t_source();
    t_disable();
    t_parity();
    t_timing();
    t_overrun();
    t_resync();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end

endmodule